// File: doc/BRIEF.md
# Command-Gated Stream Packet Releaser

This block sits in a streaming path between a buffering FIFO and a stream-to-memory DMA engine. It accepts words on a stream slave port and keeps them in a small internal buffer. It drives its stream master port only after software has authorised a transfer. The consumer's input pipeline cannot take in any word before a command exists, so the count held inside this block is the exact number of words that a transfer can move.

Software uses a small register bus with a valid strobe and a write strobe. A status register reports three things: whether at least one full packet is buffered, whether a release is in progress, and whether a start is waiting. A count register reports the exact number of buffered words. Writing the start bit while a full packet is buffered releases exactly one packet of PKT_LEN words, with TLAST on the final word. Writing it when fewer words are buffered does nothing, so a transfer never begins that could stall partway and leave stale words behind. A start written during a release is queued as one pending start when QUEUE_START is 1, and dropped when it is 0.

Top module: `pkt_gate`

## Requirements
- R1: After reset, and whenever no release is in progress, `m_valid` is 0, whatever words are buffered.
- R2: The count register (address 1) equals the number of words accepted on the slave port minus the number handed over on the master port. A cycle that accepts one word and hands over one word leaves the count unchanged.
- R3: `s_ready` is 0 when the buffer holds DEPTH (default 8) words. A word offered then is not accepted, and the count stays at DEPTH.
- R4: Status bit 0 (address 0) reads 1 when the count is at least PKT_LEN (default 4), and 0 for any smaller count, including 1 to 3.
- R5: A write to address 0 with data bit 0 set while the count is below PKT_LEN has no effect: status bit 1 (busy) stays 0, `m_valid` stays 0 and the count is unchanged.
- R6: A start written while the count is at least PKT_LEN releases exactly PKT_LEN words in arrival order. `m_valid` then returns to 0.
- R7: `m_last` is 1 on the PKT_LEN-th word of a released packet and 0 on the words before it.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged on the next cycle.
- R9: With QUEUE_START=1, start writes made during a release set status bit 2 (pending) and collapse into a single pending start. That start is taken one idle cycle after the packet ends if a full packet is buffered, which releases one more packet.
- R10: A synchronous reset (`rst` high at a clock edge) empties the buffer, clears the count, the busy state and the pending start, and drives `m_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | DATA_W | Slave stream data |
| s_valid | input | 1 | Slave stream valid |
| s_ready | output | 1 | Slave stream ready, low when the buffer is full |
| m_data | output | DATA_W | Master stream data |
| m_valid | output | 1 | Master stream valid, high only during an authorised release |
| m_ready | input | 1 | Master stream ready |
| m_last | output | 1 | Marks the final word of a packet |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Register access is a write |
| reg_addr | input | 2 | Register address: 0 status/control, 1 count |
| reg_wdata | input | 32 | Write data; bit 0 is the start bit at address 0 |
| reg_rdata | output | 32 | Read data for `reg_addr`: at address 0 bit 0 ready, bit 1 busy, bit 2 pending; at address 1 the count |

## Verification
The start bit is tried at three buffer levels. With three words buffered it must do nothing, which separates the gate from a plain pass-through. With exactly four it must release one packet and stop, which shows the word count and the TLAST position. With eight it must send the oldest words and leave the rest. The release is also driven with the consumer stalling, which checks the data hold, and with a push and a pop in the same cycle, which checks the count arithmetic. Further runs fill the buffer to its limit, queue repeated starts during a release so that they collapse into one follow-on packet, and apply a reset midway through a packet.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;
  localparam int REG_W = 32;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1
  } reg_addr_e;
  localparam int ST_READY   = 0;
  localparam int ST_BUSY    = 1;
  localparam int ST_PENDING = 2;
  localparam int CTL_START  = 0;
endpackage

// File: rtl/pkt_gate_buf.sv
module pkt_gate_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              push,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c,
                                                  input logic in_w, input logic out_w);
    return c + CNT_W'(in_w) - CNT_W'(out_w);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  assign full    = (count == CNT_W'(DEPTH));
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= wr_data;
        wptr      <= ptr_step(wptr);
      end
      if (pop) rptr <= ptr_step(rptr);
      count <= count_step(count, push, pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_count_balance_R2: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> count == $past(count));
endmodule

// File: rtl/pkt_gate_ctrl.sv
module pkt_gate_ctrl #(
  parameter int PKT_LEN     = 4,
  parameter int CNT_W       = 4,
  parameter bit QUEUE_START = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CNT_W-1:0] count,
  input  logic             m_ready,
  output logic             m_valid,
  output logic             m_last,
  output logic             pop,
  output logic             pkt_ready,
  output logic             busy,
  output logic             pending
);
  localparam int SENT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  function automatic logic have_packet(input logic [CNT_W-1:0] c);
    return c >= CNT_W'(PKT_LEN);
  endfunction

  logic [SENT_W-1:0] sent;
  logic              final_word;
  logic              pkt_done;
  logic              launch;
  logic              queue_req;

  assign pkt_ready  = have_packet(count);
  assign m_valid    = busy;
  assign final_word = (sent == SENT_W'(PKT_LEN - 1));
  assign m_last     = busy && final_word;
  assign pop        = busy && m_ready;
  assign pkt_done   = pop && final_word;
  assign launch     = !busy && (start_req || pending) && pkt_ready;

  generate
    if (QUEUE_START) begin : g_queue
      assign queue_req = busy && start_req;
    end else begin : g_drop
      assign queue_req = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sent    <= '0;
      pending <= 1'b0;
    end else if (!busy) begin
      pending <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        sent <= '0;
      end
    end else begin
      if (queue_req) pending <= 1'b1;
      if (pkt_done) begin
        busy <= 1'b0;
        sent <= '0;
      end else if (pop) begin
        sent <= sent + 1'b1;
      end
    end
  end

  assert_start_guard_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(count) >= CNT_W'(PKT_LEN));
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_last) |=> !m_valid);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_last));
  assert_pending_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_req) |=> !pending);
endmodule

// File: rtl/pkt_gate_regs.sv
module pkt_gate_regs
  import pkt_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             pkt_ready,
  input  logic             busy,
  input  logic             pending,
  output logic             start_req,
  output logic [REG_W-1:0] reg_rdata
);
  assign start_req = reg_valid && reg_write &&
                     (reg_addr == ADDR_CTRL) && reg_wdata[CTL_START];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[ST_READY]   = pkt_ready;
        reg_rdata[ST_BUSY]    = busy;
        reg_rdata[ST_PENDING] = pending;
      end
      ADDR_COUNT: reg_rdata = REG_W'(count);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pkt_gate.sv
module pkt_gate #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 8,
  parameter int PKT_LEN     = 4,
  parameter bit QUEUE_START = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_last,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic full, push, pop, start_req, pkt_ready, busy, pending;

  assign s_ready = !full;
  assign push    = s_valid && s_ready;

  pkt_gate_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .wr_data(s_data), .push(push), .pop(pop),
    .rd_data(m_data), .count(count), .full(full)
  );

  pkt_gate_ctrl #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W), .QUEUE_START(QUEUE_START)) u_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .count(count), .m_ready(m_ready),
    .m_valid(m_valid), .m_last(m_last), .pop(pop), .pkt_ready(pkt_ready),
    .busy(busy), .pending(pending)
  );

  pkt_gate_regs #(.CNT_W(CNT_W)) u_regs (
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .count(count), .pkt_ready(pkt_ready), .busy(busy),
    .pending(pending), .start_req(start_req), .reg_rdata(reg_rdata)
  );

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> $stable(m_data));
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> !m_valid && count == '0);
  assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (!m_valid && !start_req && !pending) |=> !m_valid);
endmodule

// File: tb/pkt_gate_bench.sv
module pkt_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] m_data;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic        m_last;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_gate u_pkt_gate (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] status_word(input int cnt, input bit b, input bit p);
    return {29'd0, p, b, (cnt >= 4)};
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic write_start();
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd1;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic take_word(input string req, input logic [31:0] exp_d, input bit exp_l);
    check(req, "m_valid before take", {31'd0, m_valid}, 32'd1);
    check(req, "m_data", m_data, exp_d);
    check("R7", "m_last", {31'd0, m_last}, {31'd0, exp_l});
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "m_valid after reset", {31'd0, m_valid}, 32'd0);
    check("R3", "s_ready after reset", {31'd0, s_ready}, 32'd1);
    read_reg(2'd1, v); check("R2", "count after reset", v, 32'd0);
    read_reg(2'd0, v); check("R4", "status after reset", v, status_word(0, 0, 0));
  endtask

  task automatic t_partial();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) push_word(32'hA0 + i);
    read_reg(2'd1, v); check("R2", "count after 3 pushes", v, 32'd3);
    read_reg(2'd0, v); check("R4", "ready bit with 3 words", v, status_word(3, 0, 0));
    check("R1", "m_valid idle with data", {31'd0, m_valid}, 32'd0);
    write_start();
    for (int i = 0; i < 3; i++) begin
      check("R5", "m_valid after short start", {31'd0, m_valid}, 32'd0);
      @(negedge clk);
    end
    read_reg(2'd0, v); check("R5", "busy after short start", v, status_word(3, 0, 0));
    read_reg(2'd1, v); check("R5", "count after short start", v, 32'd3);
  endtask

  task automatic t_release();
    logic [31:0] v;
    push_word(32'hA3);
    read_reg(2'd0, v); check("R4", "ready bit with 4 words", v, status_word(4, 0, 0));
    write_start();
    read_reg(2'd0, v); check("R6", "busy during release", v, status_word(4, 1, 0));
    for (int i = 0; i < 4; i++) take_word("R6", 32'hA0 + i, i == 3);
    check("R6", "m_valid after packet", {31'd0, m_valid}, 32'd0);
    read_reg(2'd1, v); check("R6", "count after packet", v, 32'd0);
  endtask

  task automatic t_stall();
    for (int i = 0; i < 4; i++) push_word(32'hB0 + i);
    write_start();
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 2; k++) begin
        check("R8", "m_valid held in stall", {31'd0, m_valid}, 32'd1);
        check("R8", "m_data held in stall", m_data, 32'hB0 + i);
        @(negedge clk);
      end
      take_word("R8", 32'hB0 + i, i == 3);
    end
    check("R6", "m_valid after stalled packet", {31'd0, m_valid}, 32'd0);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) push_word(32'hC0 + i);
    write_start();
    check("R2", "first word", m_data, 32'hC0);
    m_ready = 1'b1; s_valid = 1'b1; s_data = 32'hD0;
    @(negedge clk);
    m_ready = 1'b0; s_valid = 1'b0;
    read_reg(2'd1, v); check("R2", "count after push+pop", v, 32'd5);
    for (int i = 1; i < 4; i++) take_word("R6", 32'hC0 + i, i == 3);
    read_reg(2'd1, v); check("R2", "count after packet", v, 32'd2);
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) push_word(32'hE0 + i);
    check("R3", "s_ready when full", {31'd0, s_ready}, 32'd0);
    push_word(32'hF0);
    read_reg(2'd1, v); check("R3", "count stays at depth", v, 32'd8);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    int waits;
    write_start();
    write_start();
    read_reg(2'd0, v); check("R9", "pending set", v, status_word(8, 1, 1));
    write_start();
    take_word("R9", 32'hC4, 0);
    take_word("R9", 32'hD0, 0);
    take_word("R9", 32'hE0, 0);
    take_word("R9", 32'hE1, 1);
    check("R9", "gap after packet", {31'd0, m_valid}, 32'd0);
    waits = 0;
    while (!m_valid && waits < 4) begin
      @(negedge clk);
      waits++;
    end
    check("R9", "queued start waits", waits, 1);
    read_reg(2'd0, v); check("R9", "single pending consumed", v, status_word(4, 1, 0));
    for (int i = 2; i < 6; i++) take_word("R9", 32'hE0 + i, i == 5);
    repeat (3) @(negedge clk);
    check("R9", "no third packet", {31'd0, m_valid}, 32'd0);
    read_reg(2'd1, v); check("R9", "count drained", v, 32'd0);
  endtask

  task automatic t_reset_mid();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) push_word(32'h60 + i);
    write_start();
    write_start();
    take_word("R10", 32'h60, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10", "m_valid after reset", {31'd0, m_valid}, 32'd0);
    read_reg(2'd1, v); check("R10", "count after reset", v, 32'd0);
    read_reg(2'd0, v); check("R10", "status after reset", v, status_word(0, 0, 0));
    repeat (3) @(negedge clk);
    check("R10", "no pending release", {31'd0, m_valid}, 32'd0);
    push_word(32'h70);
    read_reg(2'd1, v); check("R10", "buffer restarted", v, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_partial();
    t_release();
    t_stall();
    t_simul();
    t_full();
    t_pending();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule